// File: doc/BRIEF.md
# Descriptor Integrity Gate

This block sits between a descriptor fetch path and a DMA channel engine. It takes a descriptor as a stream of sixteen 32-bit words, one word per accepted beat, and gives a single verdict before the engine acts on it. The verdict says whether the descriptor may be used. If it may not, the verdict also gives the first failed check and one bit in a 32-bit error layout that is indexed by channel.

Three checks run on each descriptor. The first is a fixed signature byte in the control word. The second is an optional 32-bit additive checksum. The third is a completion marker that shows the descriptor was already consumed. Separately, the fetch logic can report that a descriptor could not be read, and the block then turns that into the same kind of verdict. When a descriptor passes, the chain-control bits of the control word are decoded and passed on, so the engine knows whether to stop the chain, raise a completion interrupt or write the done marker back.

The verdict is held until the consumer accepts it. No new words are taken while a verdict is waiting.

Top module: `dsc_check`

## Requirements
- R1: A descriptor is rejected when bits [7:0] of word 0 differ from 0xA5. The error kind is 2 and the error bit is 7 plus the channel.
- R2: When bit 20 of word 0 is set, the modulo 2^32 sum of words 0 to 14 must equal word 15. Otherwise the error kind is 3 and the error bit is 13 plus the channel. When bit 20 is clear, word 15 has no effect.
- R3: When bit 31 of word 5 is set and bit 10 of word 0 is clear, the descriptor is rejected with error kind 4 and error bit 25 plus the channel. When bit 10 is set, the marker is accepted.
- R4: The checks are ranked signature first, then checksum, then completion marker. Only the highest-ranked failure is reported, so err_vec has at most one bit set.
- R5: If rd_fail is high while word_ready is high and abort is low, the partial descriptor is dropped. One cycle later a verdict appears with error kind 1, error bit 1 plus ch_sel as sampled in that cycle, and all decoded flags low.
- R6: verdict_valid rises in the cycle after the 16th word is accepted. It stays high, with all verdict outputs unchanged, until a cycle in which verdict_ready is high. It is low in the cycle after that.
- R7: word_ready is low while a verdict is held. Words offered during that time are not counted.
- R8: abort clears the word count and the partial sum. It takes priority over a word or rd_fail in the same cycle, so abort together with the 16th word gives no verdict.
- R9: The channel is sampled together with word 0. On a descriptor verdict, the flags are decoded from word 0: last_desc is bit 19, last_frame is bit 21, chain_end is their OR, want_irq is bit 8 and want_wb is bit 9.
- R10: pass is high exactly when no check failed. In that case err_kind is 0 and err_vec is zero.
- R11: After reset, verdict_valid is low and word_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_sel | input | 3 | Channel of the descriptor or read failure |
| word_valid | input | 1 | A descriptor word is offered |
| word_data | input | 32 | Descriptor word |
| word_ready | output | 1 | Block can take a word |
| abort | input | 1 | Drop the partial descriptor |
| rd_fail | input | 1 | Descriptor fetch failed |
| verdict_ready | input | 1 | Consumer takes the verdict |
| verdict_valid | output | 1 | A verdict is held |
| pass | output | 1 | Descriptor may be used |
| err_kind | output | 3 | 0 none, 1 read, 2 signature, 3 checksum, 4 already done |
| err_vec | output | 32 | One-hot error bit in the error layout |
| last_desc | output | 1 | Descriptor ends the chain |
| last_frame | output | 1 | Descriptor ends the frame |
| chain_end | output | 1 | Either end marker is set |
| want_irq | output | 1 | Completion interrupt requested |
| want_wb | output | 1 | Done-marker writeback requested |

## Verification
There are two cases where two functions land in the same cycle.

- **abort with the final beat.** The bench drives abort high in the same cycle as the 16th word. It then checks that no verdict appears, and that a clean descriptor sent next passes. A pass shows that the counter and sum restarted from zero.
- **Several failures in one descriptor.** The bench builds descriptors that fail the signature, checksum and completion checks together, and descriptors that fail only the last two. It checks that only the highest-ranked error bit is set.

The random descriptors cover the same overlaps, at random, with idle gaps between words.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

  typedef enum logic [2:0] {
    ERR_NONE     = 3'd0,
    ERR_READ     = 3'd1,
    ERR_PREAMBLE = 3'd2,
    ERR_CHECKSUM = 3'd3,
    ERR_DONE     = 3'd4
  } err_kind_e;

  localparam logic [7:0] SIGNATURE = 8'hA5;

  // control word bit positions
  localparam int CB_IRQ    = 8;
  localparam int CB_WB     = 9;
  localparam int CB_IGNORE = 10;
  localparam int CB_LAST   = 19;
  localparam int CB_CSUM   = 20;
  localparam int CB_LFRAME = 21;

  // error layout base bits, offset by channel
  localparam int BASE_READ  = 1;
  localparam int BASE_SIG   = 7;
  localparam int BASE_CSUM  = 13;
  localparam int BASE_DONE  = 25;

  typedef struct packed {
    logic [7:0] sig;
    logic       irq;
    logic       wb;
    logic       ignore;
    logic       last;
    logic       csum_en;
    logic       lframe;
  } ctl_t;

endpackage

// File: rtl/dsc_accum.sv
module dsc_accum
  import dsc_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int N_WORDS   = 16,
  parameter int CH_W      = 3,
  parameter int FLAG_WORD = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              take,
  input  logic [WORD_W-1:0] data,
  input  logic [CH_W-1:0]   ch_in,
  output ctl_t              ctl_q,
  output logic [WORD_W-1:0] sum_q,
  output logic              flag_q,
  output logic [CH_W-1:0]   ch_q,
  output logic              on_last
);
  localparam int CNT_W = $clog2(N_WORDS);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(N_WORDS - 1);
  localparam logic [CNT_W-1:0] FLAG_IDX = CNT_W'(FLAG_WORD);

  logic [CNT_W-1:0] cnt_q;

  assign on_last = (cnt_q == LAST_IDX);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt_q <= '0;
      sum_q <= '0;
    end else if (take) begin
      if (on_last) begin
        cnt_q <= '0;
        sum_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
        sum_q <= sum_q + data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q  <= '0;
      flag_q <= 1'b0;
      ch_q   <= '0;
    end else if (take) begin
      if (cnt_q == '0) begin
        ctl_q.sig     <= data[7:0];
        ctl_q.irq     <= data[CB_IRQ];
        ctl_q.wb      <= data[CB_WB];
        ctl_q.ignore  <= data[CB_IGNORE];
        ctl_q.last    <= data[CB_LAST];
        ctl_q.csum_en <= data[CB_CSUM];
        ctl_q.lframe  <= data[CB_LFRAME];
        ch_q          <= ch_in;
      end
      if (cnt_q == FLAG_IDX) begin
        flag_q <= data[WORD_W-1];
      end
    end
  end

endmodule

// File: rtl/dsc_judge.sv
module dsc_judge
  import dsc_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int CH_W   = 3,
  parameter int NUM_CH = 6
) (
  input  logic              read_fail,
  input  logic [7:0]        sig,
  input  logic              csum_en,
  input  logic              ignore,
  input  logic              flag,
  input  logic [WORD_W-1:0] sum,
  input  logic [WORD_W-1:0] check,
  input  logic [CH_W-1:0]   ch,
  output err_kind_e         kind,
  output logic [WORD_W-1:0] vec
);
  logic [NUM_CH-1:0] ch_hot;
  logic [5:0]        base;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_hot
    assign ch_hot[g] = (ch == CH_W'(g));
  end

  always_comb begin
    kind = ERR_NONE;
    base = 6'd0;
    if (read_fail) begin
      kind = ERR_READ;
      base = 6'(BASE_READ);
    end else if (sig != SIGNATURE) begin
      kind = ERR_PREAMBLE;
      base = 6'(BASE_SIG);
    end else if (csum_en && (sum != check)) begin
      kind = ERR_CHECKSUM;
      base = 6'(BASE_CSUM);
    end else if (flag && !ignore) begin
      kind = ERR_DONE;
      base = 6'(BASE_DONE);
    end
  end

  assign vec = (kind == ERR_NONE) ? '0 : (WORD_W'(ch_hot) << base);

endmodule

// File: rtl/dsc_check.sv
module dsc_check
  import dsc_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int N_WORDS   = 16,
  parameter int NUM_CH    = 6,
  parameter int FLAG_WORD = 5,
  parameter int CH_W      = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CH_W-1:0]   ch_sel,
  input  logic              word_valid,
  input  logic [WORD_W-1:0] word_data,
  output logic              word_ready,
  input  logic              abort,
  input  logic              rd_fail,
  input  logic              verdict_ready,
  output logic              verdict_valid,
  output logic              pass,
  output logic [2:0]        err_kind,
  output logic [WORD_W-1:0] err_vec,
  output logic              last_desc,
  output logic              last_frame,
  output logic              chain_end,
  output logic              want_irq,
  output logic              want_wb
);
  ctl_t              ctl_q;
  logic [WORD_W-1:0] sum_q;
  logic              flag_q;
  logic [CH_W-1:0]   ch_q;
  logic              on_last;
  logic              take, finish, rd_evt, clear;
  err_kind_e         kind;
  logic [WORD_W-1:0] vec;

  assign word_ready = !verdict_valid;
  assign take   = word_valid && word_ready && !abort && !rd_fail;
  assign finish = take && on_last;
  assign rd_evt = rd_fail && word_ready && !abort;
  assign clear  = abort || rd_evt;

  dsc_accum #(
    .WORD_W(WORD_W), .N_WORDS(N_WORDS), .CH_W(CH_W), .FLAG_WORD(FLAG_WORD)
  ) u_accum (
    .clk(clk), .rst(rst), .clear(clear), .take(take), .data(word_data),
    .ch_in(ch_sel), .ctl_q(ctl_q), .sum_q(sum_q), .flag_q(flag_q),
    .ch_q(ch_q), .on_last(on_last)
  );

  dsc_judge #(
    .WORD_W(WORD_W), .CH_W(CH_W), .NUM_CH(NUM_CH)
  ) u_judge (
    .read_fail(rd_evt), .sig(ctl_q.sig), .csum_en(ctl_q.csum_en),
    .ignore(ctl_q.ignore), .flag(flag_q), .sum(sum_q), .check(word_data),
    .ch(rd_evt ? ch_sel : ch_q), .kind(kind), .vec(vec)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      verdict_valid <= 1'b0;
      pass          <= 1'b0;
      err_kind      <= ERR_NONE;
      err_vec       <= '0;
      last_desc     <= 1'b0;
      last_frame    <= 1'b0;
      chain_end     <= 1'b0;
      want_irq      <= 1'b0;
      want_wb       <= 1'b0;
    end else if (verdict_valid) begin
      if (verdict_ready) verdict_valid <= 1'b0;
    end else if (finish || rd_evt) begin
      verdict_valid <= 1'b1;
      pass          <= (kind == ERR_NONE);
      err_kind      <= kind;
      err_vec       <= vec;
      last_desc     <= !rd_evt && ctl_q.last;
      last_frame    <= !rd_evt && ctl_q.lframe;
      chain_end     <= !rd_evt && (ctl_q.last || ctl_q.lframe);
      want_irq      <= !rd_evt && ctl_q.irq;
      want_wb       <= !rd_evt && ctl_q.wb;
    end
  end

endmodule

// File: rtl/dsc_check_sva.sv
module dsc_check_sva #(
  parameter int WORD_W  = 32,
  parameter int N_WORDS = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              word_valid,
  input logic              word_ready,
  input logic              abort,
  input logic              rd_fail,
  input logic              verdict_ready,
  input logic              verdict_valid,
  input logic              pass,
  input logic [2:0]        err_kind,
  input logic [WORD_W-1:0] err_vec
);
  localparam int CW = $clog2(N_WORDS);
  logic [CW-1:0] seen;
  logic          acc;

  assign acc = word_valid && word_ready && !abort && !rd_fail;

  always_ff @(posedge clk) begin
    if (rst || abort || (rd_fail && word_ready)) seen <= '0;
    else if (acc) seen <= (seen == CW'(N_WORDS - 1)) ? '0 : seen + 1'b1;
  end

  a_r6_verdict_after_last: assert property (@(posedge clk) disable iff (rst)
    acc && (seen == CW'(N_WORDS - 1)) |=> verdict_valid);

  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    verdict_valid && !verdict_ready |=>
      verdict_valid && $stable(err_vec) && $stable(err_kind) && $stable(pass));

  a_r6_release: assert property (@(posedge clk) disable iff (rst)
    verdict_valid && verdict_ready |=> !verdict_valid);

  a_r7_stall: assert property (@(posedge clk) disable iff (rst)
    verdict_valid |-> !word_ready);

  a_r4_single_bit: assert property (@(posedge clk) disable iff (rst)
    verdict_valid |-> $onehot0(err_vec));

  a_r10_pass_clean: assert property (@(posedge clk) disable iff (rst)
    verdict_valid |-> (pass == (err_vec == '0)) && (pass == (err_kind == 3'd0)));

  a_r8_abort_quiet: assert property (@(posedge clk) disable iff (rst)
    abort && !verdict_valid |=> !verdict_valid);

  a_r5_read_fail: assert property (@(posedge clk) disable iff (rst)
    rd_fail && word_ready && !abort |=> verdict_valid && (err_kind == 3'd1));

endmodule

bind dsc_check dsc_check_sva #(.WORD_W(WORD_W), .N_WORDS(N_WORDS)) u_sva (
  .clk(clk), .rst(rst), .word_valid(word_valid), .word_ready(word_ready),
  .abort(abort), .rd_fail(rd_fail), .verdict_ready(verdict_ready),
  .verdict_valid(verdict_valid), .pass(pass), .err_kind(err_kind),
  .err_vec(err_vec)
);

// File: tb/dsc_check_tb.sv
`timescale 1ns/1ps
module dsc_check_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  ch_sel = '0;
  logic        word_valid = 1'b0;
  logic [31:0] word_data = '0;
  logic        word_ready;
  logic        abort = 1'b0;
  logic        rd_fail = 1'b0;
  logic        verdict_ready = 1'b0;
  logic        verdict_valid, pass, last_desc, last_frame, chain_end, want_irq, want_wb;
  logic [2:0]  err_kind;
  logic [31:0] err_vec;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [31:0] w [16];

  always #2.5 clk = ~clk;

  dsc_check u_dut (
    .clk(clk), .rst(rst), .ch_sel(ch_sel), .word_valid(word_valid),
    .word_data(word_data), .word_ready(word_ready), .abort(abort),
    .rd_fail(rd_fail), .verdict_ready(verdict_ready),
    .verdict_valid(verdict_valid), .pass(pass), .err_kind(err_kind),
    .err_vec(err_vec), .last_desc(last_desc), .last_frame(last_frame),
    .chain_end(chain_end), .want_irq(want_irq), .want_wb(want_wb)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] sum15();
    logic [31:0] s = '0;
    for (int i = 0; i < 15; i++) s = s + w[i];
    return s;
  endfunction

  function automatic void model(input int ch, output logic [2:0] k, output logic [31:0] v);
    k = 3'd0; v = '0;
    if (w[0][7:0] != 8'hA5) begin k = 3'd2; v = 32'd1 << (7 + ch); end
    else if (w[0][20] && sum15() != w[15]) begin k = 3'd3; v = 32'd1 << (13 + ch); end
    else if (w[5][31] && !w[0][10]) begin k = 3'd4; v = 32'd1 << (25 + ch); end
  endfunction

  task automatic build(input bit sig_ok, input bit csum_en, input bit csum_ok,
                       input bit done, input bit ign);
    for (int i = 0; i < 16; i++) w[i] = $urandom;
    w[0][7:0] = sig_ok ? 8'hA5 : (8'hA5 ^ 8'(1 + ($urandom % 255)));
    w[0][20] = csum_en;
    w[0][10] = ign;
    w[5][31] = done;
    w[15] = csum_ok ? sum15() : sum15() + 32'd1 + ($urandom % 1000);
  endtask

  task automatic send(input int ch, input int n, input bit gaps);
    for (int i = 0; i < n; i++) begin
      if (gaps && ($urandom % 4 == 0)) begin
        @(negedge clk); word_valid = 1'b0;
      end
      @(negedge clk);
      word_valid = 1'b1; word_data = w[i];
      if (i == 0) ch_sel = 3'(ch);
    end
    @(negedge clk); word_valid = 1'b0;
  endtask

  task automatic judge(input int ch, input string tag);
    logic [2:0] k; logic [31:0] v;
    model(ch, k, v);
    chk(verdict_valid === 1'b1, "R6 verdict one cycle after last word", 32'(verdict_valid), 32'd1);
    chk(err_kind === k, {tag, " kind"}, 32'(err_kind), 32'(k));
    chk(err_vec === v, {tag, " vec"}, err_vec, v);
    chk(pass === (k == 3'd0), "R10 pass", 32'(pass), 32'(k == 3'd0));
    chk({last_desc, last_frame, chain_end, want_irq, want_wb} ===
        {w[0][19], w[0][21], w[0][19] | w[0][21], w[0][8], w[0][9]},
        "R9 flags", {27'd0, last_desc, last_frame, chain_end, want_irq, want_wb},
        {27'd0, w[0][19], w[0][21], w[0][19] | w[0][21], w[0][8], w[0][9]});
  endtask

  task automatic consume();
    @(negedge clk); verdict_ready = 1'b1;
    @(negedge clk); verdict_ready = 1'b0;
    chk(verdict_valid === 1'b0, "R6 released after consume", 32'(verdict_valid), 32'd0);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(verdict_valid === 1'b0, "R11 reset verdict_valid", 32'(verdict_valid), 32'd0);
    chk(word_ready === 1'b1, "R11 reset word_ready", 32'(word_ready), 32'd1);

    // R2 clean descriptor with checksum on
    build(1, 1, 1, 0, 0); send(2, 16, 0); judge(2, "R2 good sum"); consume();
    // R2 checksum off, word 15 garbage
    build(1, 0, 0, 0, 0); send(0, 16, 0); judge(0, "R2 sum disabled");
    chk(pass === 1'b1, "R2 disabled sum passes", 32'(pass), 32'd1); consume();
    // R4 all three fail: signature wins
    build(0, 1, 0, 1, 0); send(4, 16, 0); judge(4, "R4 R1 signature first");
    chk(err_vec === 32'd1 << 11, "R1 bit 7+n", err_vec, 32'd1 << 11); consume();
    // R4 checksum and done fail: checksum wins
    build(1, 1, 0, 1, 0); send(1, 16, 0); judge(1, "R4 checksum before done");
    chk(err_vec === 32'd1 << 14, "R2 bit 13+n", err_vec, 32'd1 << 14); consume();
    // R3 done rejected / ignored
    build(1, 0, 0, 1, 0); send(5, 16, 1); judge(5, "R3 done rejected");
    chk(err_vec === 32'd1 << 30, "R3 bit 25+n", err_vec, 32'd1 << 30); consume();
    build(1, 0, 0, 1, 1); send(3, 16, 1); judge(3, "R3 ignore done");
    chk(pass === 1'b1, "R3 ignore bit passes", 32'(pass), 32'd1);

    // R6 hold while not consumed; R7 words ignored
    repeat (3) @(negedge clk);
    chk(verdict_valid === 1'b1, "R6 held", 32'(verdict_valid), 32'd1);
    chk(word_ready === 1'b0, "R7 word_ready low while held", 32'(word_ready), 32'd0);
    word_valid = 1'b1; word_data = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    word_valid = 1'b0;
    consume();
    build(1, 1, 1, 0, 0); send(2, 16, 0); judge(2, "R7 stray words not counted"); consume();

    // R8 abort mid-descriptor
    build(0, 0, 0, 0, 0); send(1, 7, 0);
    @(negedge clk); abort = 1'b1;
    @(negedge clk); abort = 1'b0;
    build(1, 1, 1, 0, 0); send(1, 16, 0); judge(1, "R8 abort restarts"); consume();
    // R8 abort on the final beat
    build(1, 0, 0, 0, 0); send(0, 15, 0);
    @(negedge clk); word_valid = 1'b1; word_data = w[15]; abort = 1'b1;
    @(negedge clk); word_valid = 1'b0; abort = 1'b0;
    chk(verdict_valid === 1'b0, "R8 abort beats last word", 32'(verdict_valid), 32'd0);
    build(1, 1, 1, 0, 0); send(3, 16, 0); judge(3, "R8 clean after abort"); consume();

    // R5 read failure mid-stream
    build(1, 0, 0, 0, 0); send(0, 4, 0);
    @(negedge clk); rd_fail = 1'b1; ch_sel = 3'd3;
    @(negedge clk); rd_fail = 1'b0;
    chk(verdict_valid === 1'b1, "R5 verdict after read fail", 32'(verdict_valid), 32'd1);
    chk(err_kind === 3'd1, "R5 kind", 32'(err_kind), 32'd1);
    chk(err_vec === 32'd1 << 4, "R5 bit 1+n", err_vec, 32'd1 << 4);
    chk(chain_end === 1'b0, "R5 flags low", 32'(chain_end), 32'd0);
    consume();

    // random mix
    for (int t = 0; t < 300; t++) begin
      int ch = $urandom % 6;
      build(($urandom % 8) != 0, $urandom % 2, ($urandom % 3) != 0, $urandom % 2, $urandom % 2);
      send(ch, 16, 1);
      judge(ch, "R1 R2 R3 random");
      consume();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule